// File: doc/BRIEF.md
# Blind Control-Channel Candidate Sequencer

This block runs a blind search over downlink control-channel candidates. A search covers three aggregation levels (4, 8 and 16), each with its own candidate count, and repeats the whole set over two monitored slots. The candidate data and the three decoding engines sit outside the block. The sequencer tells the candidate source which candidate it wants next (slot, level, index within level), raises a ready when it can take that candidate, and then runs three engine stages in order through start/done handshakes: estimation/equalization/demodulation/descrambling, then rate recovery, then polar plus CRC decoding.

The search ends at the first candidate whose CRC passes. The sequencer then keeps the 41-bit decoded word and the slot in which it was found, and raises a done valid. If every candidate fails, it raises done valid together with a search-failed flag. A 3-bit status shows progress at all times. A new start from a finished search clears the results and begins again. A start that arrives while a search is running has no effect.

Top module: `blind_cand_seq`

## Requirements
- R1: After reset, status is 0, cand_ready, done_valid and search_fail are 0, dci_word is 0, and no engine start is asserted.
- R2: A start pulse in status 0, 5 or 6 with at least one nonzero count gives status 1 and cand_ready 1 one cycle later. A candidate is taken in the cycle where cand_valid and cand_ready are both high, and cand_ready then drops.
- R3: Taking a candidate pulses est_start for one cycle, with status 1. est_done in that stage pulses rr_start, with status 2. rr_done in that stage pulses dec_start, with status 3. A done pulse that arrives outside its own stage has no effect.
- R4: Candidates are offered in this order. Level code 0 (level 4) comes first, then code 1 (level 8), then code 2 (level 16). Within a level, the index runs from 0 to count-1. Every candidate in slot 0 is offered before any candidate in slot 1. A level whose count is zero is skipped.
- R5: A CRC failure that is not on the final candidate gives status 4, with cand_ready high and the cand_slot, cand_level and cand_idx outputs showing the next candidate.
- R6: A CRC pass gives status 6, done_valid 1 and search_fail 0 one cycle after dec_done. dci_word holds the decoded word and dci_slot holds the slot of the passing candidate. The search stops there.
- R7: A CRC failure on the final candidate gives status 5 with done_valid 1 and search_fail 1. A start with all three counts zero goes straight to this result.
- R8: A start pulse while status is 1 to 4 is ignored. The status, the candidate position and the results do not change.
- R9: A start from status 5 or 6 clears dci_word, dci_slot, search_fail and done_valid in the same cycle that the new search begins.
- R10: A search that exhausts its candidates tries exactly twice the sum of the three counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new search (ignored while busy) |
| cnt_al4 | input | 3 | Candidate count at aggregation level 4 |
| cnt_al8 | input | 3 | Candidate count at aggregation level 8 |
| cnt_al16 | input | 3 | Candidate count at aggregation level 16 |
| cand_valid | input | 1 | Candidate data is being supplied |
| cand_ready | output | 1 | Sequencer can accept the next candidate |
| cand_slot | output | 1 | Slot of the requested candidate |
| cand_level | output | 2 | Level code of the requested candidate (0=4, 1=8, 2=16) |
| cand_idx | output | 3 | Index of the requested candidate within its level |
| est_start | output | 1 | Start pulse for the estimation/demodulation engine |
| est_done | input | 1 | Done pulse from the estimation/demodulation engine |
| rr_start | output | 1 | Start pulse for the rate recovery engine |
| rr_done | input | 1 | Done pulse from the rate recovery engine |
| dec_start | output | 1 | Start pulse for the polar/CRC engine |
| dec_done | input | 1 | Done pulse from the polar/CRC engine |
| crc_pass | input | 1 | CRC result, qualified by dec_done |
| dec_word | input | 41 | Decoded word, qualified by dec_done |
| status | output | 3 | Search progress code |
| dci_word | output | 41 | Decoded control word of the passing candidate |
| dci_slot | output | 1 | Slot in which the passing candidate was found |
| search_fail | output | 1 | No candidate passed |
| done_valid | output | 1 | Search finished; results valid |

## Verification
The assertions assume that each engine's done is a single-cycle pulse, that it comes only after that engine's own start, and that only one engine is busy at a time. They also assume that cand_valid is driven only while cand_ready is high. The check that a start during a busy search is ignored holds only in cycles with no handshake input active. The stimulus follows all of these rules. Its engine model answers each start pulse once, on the next cycle, and raises cand_valid for exactly one cycle while ready is high. The two deliberate violations are a start pulse and a stray rr_done, both sent during the estimation stage, and both sit in a cycle where the design must hold its state.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int LVL_N  = 3;
  localparam int CNT_W  = 3;
  localparam int WORD_W = 41;
  localparam int SLOT_N = 2;
  localparam int LVL_W  = (LVL_N > 1) ? $clog2(LVL_N) : 1;
  localparam int SLOT_W = (SLOT_N > 1) ? $clog2(SLOT_N) : 1;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_EST     = 3'd1,
    ST_RR      = 3'd2,
    ST_DEC     = 3'd3,
    ST_RETRY   = 3'd4,
    ST_EXHAUST = 3'd5,
    ST_FOUND   = 3'd6,
    ST_FIRST   = 3'd7
  } seq_state_e;
endpackage

// File: rtl/cs_cand_walker.sv
module cs_cand_walker #(
  parameter int LVL_N  = cs_pkg::LVL_N,
  parameter int CNT_W  = cs_pkg::CNT_W,
  parameter int SLOT_N = cs_pkg::SLOT_N,
  localparam int LVL_W  = (LVL_N > 1) ? $clog2(LVL_N) : 1,
  localparam int SLOT_W = (SLOT_N > 1) ? $clog2(SLOT_N) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             load_i,
  input  logic                             step_i,
  input  logic                             active_i,
  input  logic [LVL_N-1:0][CNT_W-1:0]      cnt_i,
  output logic [LVL_W-1:0]                 level_o,
  output logic [CNT_W-1:0]                 idx_o,
  output logic [SLOT_W-1:0]                slot_o,
  output logic                             last_o,
  output logic                             any_o
);
  logic [LVL_N-1:0][CNT_W-1:0] cnt_q;
  logic [LVL_W-1:0]            level_q, nxt_level;
  logic [CNT_W-1:0]            idx_q, nxt_idx;
  logic [SLOT_W-1:0]           slot_q, nxt_slot;
  logic                        more, found;

  function automatic logic [LVL_W-1:0] first_nz(input logic [LVL_N-1:0][CNT_W-1:0] c);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int l = LVL_N - 1; l >= 0; l--) begin
      if (c[l] != '0) r = LVL_W'(l);
    end
    return r;
  endfunction

  always_comb begin
    any_o = 1'b0;
    for (int l = 0; l < LVL_N; l++) begin
      if (cnt_i[l] != '0) any_o = 1'b1;
    end
  end

  // Next position in search order: index, then higher level, then next slot
  always_comb begin
    nxt_level = level_q;
    nxt_idx   = idx_q;
    nxt_slot  = slot_q;
    more      = 1'b0;
    found     = 1'b0;
    if ((CNT_W+1)'(idx_q) + 1'b1 < (CNT_W+1)'(cnt_q[level_q])) begin
      nxt_idx = idx_q + 1'b1;
      more    = 1'b1;
    end else begin
      for (int l = 0; l < LVL_N; l++) begin
        if (!found && (l > int'(level_q)) && (cnt_q[l] != '0)) begin
          nxt_level = LVL_W'(l);
          found     = 1'b1;
        end
      end
      if (found) begin
        nxt_idx = '0;
        more    = 1'b1;
      end else if (int'(slot_q) < SLOT_N - 1) begin
        nxt_slot  = slot_q + 1'b1;
        nxt_level = first_nz(cnt_q);
        nxt_idx   = '0;
        more      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      level_q <= '0;
      idx_q   <= '0;
      slot_q  <= '0;
    end else if (load_i) begin
      cnt_q   <= cnt_i;
      level_q <= first_nz(cnt_i);
      idx_q   <= '0;
      slot_q  <= '0;
    end else if (step_i && more) begin
      level_q <= nxt_level;
      idx_q   <= nxt_idx;
      slot_q  <= nxt_slot;
    end
  end

  assign level_o = level_q;
  assign idx_o   = idx_q;
  assign slot_o  = slot_q;
  assign last_o  = !more;

  // R4
  idx_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    active_i |-> ((CNT_W+1)'(idx_q) < (CNT_W+1)'(cnt_q[level_q])));

  // R4
  slot_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i) |=> (slot_q >= $past(slot_q)));
endmodule

// File: rtl/cs_stage_fsm.sv
module cs_stage_fsm
  import cs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       cand_valid_i,
  input  logic       est_done_i,
  input  logic       rr_done_i,
  input  logic       dec_done_i,
  input  logic       crc_pass_i,
  input  logic       last_i,
  input  logic       any_i,
  output logic [2:0] status_o,
  output logic       cand_ready_o,
  output logic       est_start_o,
  output logic       rr_start_o,
  output logic       dec_start_o,
  output logic       load_o,
  output logic       step_o,
  output logic       pass_o,
  output logic       exhaust_o
);
  seq_state_e state_q, state_d;
  logic       idle_like, dec_fin;
  logic [2:0] status_q;
  logic       ready_q, est_q, rr_q, dec_q;

  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_EXHAUST) || (state_q == ST_FOUND);
  assign dec_fin   = (state_q == ST_DEC) && dec_done_i;
  assign load_o    = idle_like && start_i;
  assign step_o    = dec_fin && !crc_pass_i && !last_i;
  assign pass_o    = dec_fin && crc_pass_i;
  assign exhaust_o = (dec_fin && !crc_pass_i && last_i) || (load_o && !any_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_EXHAUST, ST_FOUND:
        if (start_i) state_d = any_i ? ST_FIRST : ST_EXHAUST;
      ST_FIRST, ST_RETRY:
        if (cand_valid_i) state_d = ST_EST;
      ST_EST:
        if (est_done_i) state_d = ST_RR;
      ST_RR:
        if (rr_done_i) state_d = ST_DEC;
      ST_DEC:
        if (dec_done_i) begin
          if (crc_pass_i)  state_d = ST_FOUND;
          else if (last_i) state_d = ST_EXHAUST;
          else             state_d = ST_RETRY;
        end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      status_q <= 3'd0;
      ready_q  <= 1'b0;
      est_q    <= 1'b0;
      rr_q     <= 1'b0;
      dec_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      status_q <= (state_d == ST_FIRST) ? 3'd1 : 3'(state_d);
      ready_q  <= (state_d == ST_FIRST) || (state_d == ST_RETRY);
      est_q    <= (state_q != ST_EST) && (state_d == ST_EST);
      rr_q     <= (state_q != ST_RR)  && (state_d == ST_RR);
      dec_q    <= (state_q != ST_DEC) && (state_d == ST_DEC);
    end
  end

  assign status_o     = status_q;
  assign cand_ready_o = ready_q;
  assign est_start_o  = est_q;
  assign rr_start_o   = rr_q;
  assign dec_start_o  = dec_q;

  // R3
  stage_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ready_q, est_q, rr_q, dec_q}));

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !idle_like && !cand_valid_i && !est_done_i && !rr_done_i && !dec_done_i)
      |=> $stable(status_q));

  // R6
  found_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((status_q == 3'd6) && !start_i) |=> (status_q == 3'd6));
endmodule

// File: rtl/cs_result_reg.sv
module cs_result_reg #(
  parameter int WORD_W = cs_pkg::WORD_W,
  parameter int SLOT_W = cs_pkg::SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              capture_i,
  input  logic              fail_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [WORD_W-1:0] word_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              fail_o,
  output logic              done_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_o <= '0;
      slot_o <= '0;
      fail_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      if (clear_i) begin
        word_o <= '0;
        slot_o <= '0;
        fail_o <= 1'b0;
        done_o <= 1'b0;
      end
      if (capture_i) begin
        word_o <= word_i;
        slot_o <= slot_i;
        done_o <= 1'b1;
      end
      if (fail_i) begin
        fail_o <= 1'b1;
        done_o <= 1'b1;
      end
    end
  end

  // R7
  fail_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> done_o);

  // R6
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !clear_i) |=> $stable(word_o));
endmodule

// File: rtl/blind_cand_seq.sv
module blind_cand_seq
  import cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  cnt_al4,
  input  logic [CNT_W-1:0]  cnt_al8,
  input  logic [CNT_W-1:0]  cnt_al16,
  input  logic              cand_valid,
  output logic              cand_ready,
  output logic [SLOT_W-1:0] cand_slot,
  output logic [LVL_W-1:0]  cand_level,
  output logic [CNT_W-1:0]  cand_idx,
  output logic              est_start,
  input  logic              est_done,
  output logic              rr_start,
  input  logic              rr_done,
  output logic              dec_start,
  input  logic              dec_done,
  input  logic              crc_pass,
  input  logic [WORD_W-1:0] dec_word,
  output logic [2:0]        status,
  output logic [WORD_W-1:0] dci_word,
  output logic [SLOT_W-1:0] dci_slot,
  output logic              search_fail,
  output logic              done_valid
);
  logic [LVL_N-1:0][CNT_W-1:0] counts;
  logic load, step, pass, exhaust, last, any_cnt;

  assign counts = {cnt_al16, cnt_al8, cnt_al4};

  cs_cand_walker #(.LVL_N(LVL_N), .CNT_W(CNT_W), .SLOT_N(SLOT_N)) u_walker (
    .clk(clk), .rst(rst), .load_i(load), .step_i(step), .active_i(cand_ready),
    .cnt_i(counts), .level_o(cand_level), .idx_o(cand_idx), .slot_o(cand_slot),
    .last_o(last), .any_o(any_cnt)
  );

  cs_stage_fsm u_fsm (
    .clk(clk), .rst(rst), .start_i(start), .cand_valid_i(cand_valid),
    .est_done_i(est_done), .rr_done_i(rr_done), .dec_done_i(dec_done),
    .crc_pass_i(crc_pass), .last_i(last), .any_i(any_cnt),
    .status_o(status), .cand_ready_o(cand_ready), .est_start_o(est_start),
    .rr_start_o(rr_start), .dec_start_o(dec_start), .load_o(load),
    .step_o(step), .pass_o(pass), .exhaust_o(exhaust)
  );

  cs_result_reg #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_result (
    .clk(clk), .rst(rst), .clear_i(load), .capture_i(pass), .fail_i(exhaust),
    .word_i(dec_word), .slot_i(cand_slot), .word_o(dci_word), .slot_o(dci_slot),
    .fail_o(search_fail), .done_o(done_valid)
  );

  // R7
  fail_status_chk: assert property (@(posedge clk) disable iff (rst)
    search_fail |-> (status == 3'd5));

  // R6
  pass_status_chk: assert property (@(posedge clk) disable iff (rst)
    (done_valid && !search_fail) |-> (status == 3'd6));
endmodule

// File: tb/blind_cand_seq_tb.sv
module blind_cand_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2:0] cnt_al4 = '0, cnt_al8 = '0, cnt_al16 = '0;
  logic cand_valid = 1'b0, est_done = 1'b0, rr_done = 1'b0, dec_done = 1'b0, crc_pass = 1'b0;
  logic [40:0] dec_word = '0;
  logic cand_ready, est_start, rr_start, dec_start, search_fail, done_valid;
  logic [0:0] cand_slot, dci_slot;
  logic [1:0] cand_level;
  logic [2:0] cand_idx, status;
  logic [40:0] dci_word;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  blind_cand_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .cnt_al4(cnt_al4), .cnt_al8(cnt_al8),
    .cnt_al16(cnt_al16), .cand_valid(cand_valid), .cand_ready(cand_ready),
    .cand_slot(cand_slot), .cand_level(cand_level), .cand_idx(cand_idx),
    .est_start(est_start), .est_done(est_done), .rr_start(rr_start), .rr_done(rr_done),
    .dec_start(dec_start), .dec_done(dec_done), .crc_pass(crc_pass), .dec_word(dec_word),
    .status(status), .dci_word(dci_word), .dci_slot(dci_slot),
    .search_fail(search_fail), .done_valid(done_valid)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {cnt4, cnt8, cnt16, pass ordinal (255 = none), word}
  localparam int NV = 6;
  localparam logic [57:0] VECS [0:NV-1] = '{
    {3'd2, 3'd1, 3'd0, 8'd255, 41'h0},
    {3'd1, 3'd2, 3'd1, 8'd2,   41'h1ABCDEF0123},
    {3'd0, 3'd3, 3'd0, 8'd4,   41'h0F0F0F0F0F0},
    {3'd0, 3'd0, 3'd2, 8'd0,   41'h15555555555},
    {3'd7, 3'd7, 3'd7, 8'd255, 41'h0},
    {3'd3, 3'd0, 3'd1, 8'd7,   41'h1FFFFFFFFFF}
  };

  task automatic pulse_start(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c);
    cnt_al4 = a; cnt_al8 = b; cnt_al16 = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // One candidate through all three stages; returns after the result edge
  task automatic run_cand(input bit pass, input logic [40:0] w);
    cand_valid = 1'b1;
    @(negedge clk);
    cand_valid = 1'b0;
    chk(est_start && status == 3'd1 && !cand_ready, "R3 est stage", {61'd0, status}, 64'd1);
    est_done = 1'b1;
    @(negedge clk);
    est_done = 1'b0;
    chk(rr_start && status == 3'd2, "R3 rr stage", {61'd0, status}, 64'd2);
    rr_done = 1'b1;
    @(negedge clk);
    rr_done = 1'b0;
    chk(dec_start && status == 3'd3, "R3 dec stage", {61'd0, status}, 64'd3);
    dec_done = 1'b1; crc_pass = pass; dec_word = w;
    @(negedge clk);
    dec_done = 1'b0; crc_pass = 1'b0; dec_word = '0;
  endtask

  task automatic run_vec(input logic [57:0] v);
    logic [2:0] cn [0:2];
    int pass_ord, total, ord, tried, found_slot;
    bit stop;
    cn[0] = v[57:55]; cn[1] = v[54:52]; cn[2] = v[51:49];
    pass_ord = int'(v[48:41]);
    total = 2 * (int'(cn[0]) + int'(cn[1]) + int'(cn[2]));
    ord = 0; tried = 0; stop = 0; found_slot = 0;
    pulse_start(cn[0], cn[1], cn[2]);
    chk(status == 3'd1 && cand_ready && !done_valid, "R2 search begins", {61'd0, status}, 64'd1);
    for (int s = 0; s < 2; s++) begin
      for (int l = 0; l < 3; l++) begin
        for (int i = 0; i < int'(cn[l]); i++) begin
          if (!stop) begin
            chk(cand_ready && cand_slot == 1'(s) && cand_level == 2'(l) && cand_idx == 3'(i),
                "R4 candidate order", {57'd0, cand_slot, cand_level, cand_idx, cand_ready},
                {57'd0, 1'(s), 2'(l), 3'(i), 1'b1});
            run_cand(ord == pass_ord, v[40:0]);
            tried = tried + 1;
            if (ord == pass_ord) begin
              stop = 1;
              found_slot = s;
            end else if (ord != total - 1) begin
              chk(status == 3'd4 && cand_ready, "R5 retry", {61'd0, status}, 64'd4);
            end
            ord = ord + 1;
          end
        end
      end
    end
    if (pass_ord != 255) begin
      chk(status == 3'd6 && done_valid && !search_fail, "R6 pass status", {61'd0, status}, 64'd6);
      chk(dci_word == v[40:0], "R6 word", {23'd0, dci_word}, {23'd0, v[40:0]});
      chk(dci_slot == 1'(found_slot), "R6 slot", {63'd0, dci_slot}, 64'(found_slot));
      chk(!cand_ready, "R6 search stops", {63'd0, cand_ready}, 64'd0);
    end else begin
      chk(status == 3'd5 && done_valid && search_fail, "R7 exhausted",
          {59'd0, status, done_valid, search_fail}, {59'd0, 3'd5, 1'b1, 1'b1});
      chk(tried == total, "R10 tried count", 64'(tried), 64'(total));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(status == 3'd0 && !cand_ready && !done_valid && !search_fail && dci_word == '0 &&
        !est_start && !rr_start && !dec_start, "R1 reset state", {61'd0, status}, 64'd0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R8 / R3: start and a stray rr_done during the estimation stage
    pulse_start(3'd1, 3'd0, 3'd0);
    cand_valid = 1'b1;
    @(negedge clk);
    cand_valid = 1'b0;
    start = 1'b1; rr_done = 1'b1;
    @(negedge clk);
    start = 1'b0; rr_done = 1'b0;
    chk(status == 3'd1 && !est_start && !rr_start && !done_valid, "R8 start ignored when busy",
        {61'd0, status}, 64'd1);
    chk(cand_slot == 1'b0 && cand_level == 2'd0, "R8 position kept", {63'd0, cand_slot}, 64'd0);
    est_done = 1'b1;
    @(negedge clk);
    est_done = 1'b0;
    chk(status == 3'd2 && rr_start, "R3 stray done ignored", {61'd0, status}, 64'd2);
    rr_done = 1'b1;
    @(negedge clk);
    rr_done = 1'b0;
    dec_done = 1'b1; crc_pass = 1'b0;
    @(negedge clk);
    dec_done = 1'b0;
    chk(status == 3'd4 && cand_slot == 1'b1 && cand_level == 2'd0 && cand_idx == 3'd0,
        "R5 R4 wrap to slot 1", {60'd0, status, cand_slot}, {60'd0, 3'd4, 1'b1});
    run_cand(1'b1, 41'h00000C0FFEE);
    chk(status == 3'd6 && dci_slot == 1'b1 && dci_word == 41'h00000C0FFEE, "R6 slot 1 pass",
        {23'd0, dci_word}, 64'h00000C0FFEE);

    // R9 / R7: restart from 6 with all counts zero
    pulse_start(3'd0, 3'd0, 3'd0);
    chk(status == 3'd5 && done_valid && search_fail && dci_word == '0 && dci_slot == 1'b0,
        "R9 R7 zero counts clear and fail", {23'd0, dci_word}, 64'd0);
    // R9: restart from 5 clears flags
    pulse_start(3'd1, 3'd0, 3'd0);
    chk(status == 3'd1 && !done_valid && !search_fail && dci_word == '0, "R9 restart clears",
        {62'd0, done_valid, search_fail}, 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule